// File: doc/BRIEF.md
# Interrupt Level-Priority Arbiter with Wake Decision

This block looks at every interrupt line of one hart and picks one winner among those that are both pending and enabled. Each line carries a privilege mode and an 8-bit control byte. The control byte is split into an interrupt level and a priority. The split point comes from a level-bit count that is configured separately for each privilege mode. Only the top `CTL_BITS` bits of each control byte exist in hardware, and every missing bit reads as one.

Candidates are ranked in this order: privilege mode first, then decoded level, then priority. A full tie goes to the higher interrupt ID. The winner is then compared with the hart's current privilege mode, its current interrupt level, the threshold of that mode and that mode's global enable. From this comparison the block produces two decisions. The first says whether the interrupt should be taken now. The second says whether a hart stalled in wait-for-interrupt should resume.

The ranking network is purely combinational. Every output is captured in one register stage, so the outputs describe the inputs sampled at the previous rising clock edge.

Top module: `irq_level_arbiter`

## Requirements
- R1: Only a line with both `irq_pend[i]` and `irq_en[i]` set can win. When no line qualifies, `win_valid`, `take_irq` and `wake_req` are 0.
- R2: Privilege is compared first, using the encoding 2'b11 machine, 2'b01 supervisor and 2'b00 user. A higher privilege wins whatever its level.
- R3: The decoded level takes the top n bits of the effective control byte, with all lower bits set to one. Here n is the level-bit count of the line's mode, clamped to 8. When n is 0, every level is 255.
- R4: Only the top `CTL_BITS` bits of each control byte are used, and the lower bits read as one. With `CTL_BITS`=1 and n=8, the only possible levels are 127 and 255.
- R5: Among winners of equal privilege and level, the larger priority wins. The priority is the effective control byte with its top n bits cleared. `win_prio` reports that value.
- R6: When privilege, level and priority are all equal, the higher interrupt ID wins.
- R7: Only `THRESH_BITS` threshold bits are used, left-justified, with the missing low bits read as one. With 2 bits, the effective thresholds are 63, 127, 191 and 255.
- R8: A winner at the current privilege is taken only when three conditions all hold: its level exceeds `cur_level`, its level exceeds the effective threshold, and `cur_gie` is set.
- R9: A winner above the current privilege is taken whenever its level is non-zero, regardless of `cur_gie`. A winner below the current privilege is never taken.
- R10: `wake_req` ignores `cur_gie`. A winner at a different privilege wakes the hart when its level is non-zero. A winner at the current privilege wakes it when its level exceeds both `cur_level` and the effective threshold.
- R11: A winner of level 0 gives neither take nor wake, even when a lower-mode line with a non-zero level is pending.
- R12: All outputs are 0 during reset. Each output reflects the inputs of the previous rising edge: one register stage and no other delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | NUM_IRQ | Pending bit of each line |
| irq_en | input | NUM_IRQ | Enable bit of each line |
| irq_mode | input | 2*NUM_IRQ | Privilege of each line, 2 bits per line |
| irq_ctl | input | 8*NUM_IRQ | Control byte of each line |
| lvl_bits_m | input | 4 | Level-bit count for machine-mode lines |
| lvl_bits_s | input | 4 | Level-bit count for supervisor-mode lines |
| lvl_bits_u | input | 4 | Level-bit count for user-mode lines |
| cur_priv | input | 2 | Current privilege of the hart |
| cur_level | input | 8 | Interrupt level the hart is running at |
| cur_thresh | input | THRESH_BITS | Threshold of the current mode, left-justified |
| cur_gie | input | 1 | Global interrupt enable of the current mode |
| win_valid | output | 1 | A qualifying winner exists |
| win_id | output | IDW | Winner's interrupt ID |
| win_priv | output | 2 | Winner's privilege |
| win_level | output | 8 | Winner's decoded level |
| win_prio | output | 8 | Winner's decoded priority |
| take_irq | output | 1 | Winner should be taken now |
| wake_req | output | 1 | Winner should end a wait-for-interrupt stall |

## Verification
The assertions assume that `irq_mode` never holds the reserved value 2'b10 and that `cur_priv` is always one of the three legal encodings. They also assume the inputs are stable around each rising edge, because they compare outputs with checker-registered copies of the inputs from the previous edge. The bench drives inputs only on falling edges and uses only legal mode codes. Every stimulus keeps at least one cycle between a change and the sample that depends on it.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int unsigned PRIV_W = 2;
  localparam int unsigned BYTE_W = 8;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  typedef struct packed {
    logic              valid;
    logic [PRIV_W-1:0] priv;
    logic [BYTE_W-1:0] level;
    logic [BYTE_W-1:0] prio;
  } irq_cand_t;

  // Ones in the low positions that are not backed by implemented bits.
  function automatic logic [7:0] low_ones(input int unsigned kept);
    int unsigned k;
    k = (kept > 8) ? 8 : kept;
    return 8'hFF >> k;
  endfunction

  // Keep only the top 'kept' bits of a byte and read the rest as one.
  function automatic logic [7:0] ones_fill(input logic [7:0] raw, input int unsigned kept);
    return raw | low_ones(kept);
  endfunction

  // Level: top n bits of the byte, with every lower bit set.
  function automatic logic [7:0] split_level(input logic [7:0] eff, input logic [3:0] n);
    return eff | low_ones(int'(n));
  endfunction

  // Priority: whatever remains below the level field.
  function automatic logic [7:0] split_prio(input logic [7:0] eff, input logic [3:0] n);
    return eff & low_ones(int'(n));
  endfunction

  // Rank key: privilege, then level, then priority.
  function automatic logic [17:0] rank_key(input irq_cand_t c);
    return {c.priv, c.level, c.prio};
  endfunction

endpackage

// File: rtl/irq_ctl_decode.sv
module irq_ctl_decode
  import irq_arb_pkg::*;
#(
  parameter int unsigned CTL_BITS = 8
) (
  input  logic       pend,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic [7:0] ctl,
  input  logic [3:0] nl_m,
  input  logic [3:0] nl_s,
  input  logic [3:0] nl_u,
  output irq_cand_t  cand
);
  logic [7:0] ctl_eff;
  logic [3:0] nl_sel;

  always_comb begin
    unique case (mode)
      PRIV_M:  nl_sel = nl_m;
      PRIV_S:  nl_sel = nl_s;
      default: nl_sel = nl_u;
    endcase
  end

  assign ctl_eff    = ones_fill(ctl, CTL_BITS);
  assign cand.valid = pend & en;
  assign cand.priv  = mode;
  assign cand.level = split_level(ctl_eff, nl_sel);
  assign cand.prio  = split_prio(ctl_eff, nl_sel);
endmodule

// File: rtl/irq_rank_tree.sv
module irq_rank_tree
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned IDW     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  irq_cand_t          cand [NUM_IRQ],
  output irq_cand_t          best,
  output logic [IDW-1:0]     best_id
);
  localparam int unsigned DEPTH = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int unsigned PAD   = 1 << DEPTH;

  for (genvar lv = 0; lv <= DEPTH; lv++) begin : g_lv
    localparam int unsigned W = PAD >> lv;
    irq_cand_t      c  [W];
    logic [IDW-1:0] id [W];
    if (lv == 0) begin : g_leaf
      for (genvar i = 0; i < W; i++) begin : g_in
        if (i < NUM_IRQ) begin : g_real
          assign c[i]  = cand[i];
        end else begin : g_pad
          assign c[i]  = '0;
        end
        assign id[i] = IDW'(i);
      end
    end else begin : g_node
      for (genvar j = 0; j < W; j++) begin : g_cmp
        irq_cand_t      lo_c, hi_c;
        logic [IDW-1:0] lo_id, hi_id;
        logic           pick_hi;
        assign lo_c  = g_lv[lv-1].c[2*j];
        assign hi_c  = g_lv[lv-1].c[2*j+1];
        assign lo_id = g_lv[lv-1].id[2*j];
        assign hi_id = g_lv[lv-1].id[2*j+1];
        // The upper half always holds larger IDs, so >= gives ties to them.
        assign pick_hi = hi_c.valid & (~lo_c.valid | (rank_key(hi_c) >= rank_key(lo_c)));
        assign c[j]  = pick_hi ? hi_c  : lo_c;
        assign id[j] = pick_hi ? hi_id : lo_id;
      end
    end
  end

  assign best    = g_lv[DEPTH].c[0];
  assign best_id = g_lv[DEPTH].id[0];
endmodule

// File: rtl/irq_take_gate.sv
module irq_take_gate
  import irq_arb_pkg::*;
(
  input  irq_cand_t  best,
  input  logic [1:0] cur_priv,
  input  logic [7:0] cur_level,
  input  logic [7:0] th_eff,
  input  logic       cur_gie,
  output logic       take,
  output logic       wake
);
  logic       above, same, nonzero, beats;
  logic [7:0] floor_lvl;

  assign above     = best.priv > cur_priv;
  assign same      = best.priv == cur_priv;
  assign nonzero   = best.level != 8'd0;
  assign floor_lvl = (cur_level > th_eff) ? cur_level : th_eff;
  assign beats     = best.level > floor_lvl;

  assign take = best.valid & ((above & nonzero) | (same & beats & cur_gie));
  assign wake = best.valid & ((~same & nonzero) | (same & beats));
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_IRQ     = 8,
  parameter int unsigned CTL_BITS    = 8,
  parameter int unsigned THRESH_BITS = 8,
  parameter int unsigned IDW         = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_IRQ-1:0]     irq_pend,
  input  logic [NUM_IRQ-1:0]     irq_en,
  input  logic [2*NUM_IRQ-1:0]   irq_mode,
  input  logic [8*NUM_IRQ-1:0]   irq_ctl,
  input  logic [3:0]             lvl_bits_m,
  input  logic [3:0]             lvl_bits_s,
  input  logic [3:0]             lvl_bits_u,
  input  logic [1:0]             cur_priv,
  input  logic [7:0]             cur_level,
  input  logic [THRESH_BITS-1:0] cur_thresh,
  input  logic                   cur_gie,
  output logic                   win_valid,
  output logic [IDW-1:0]         win_id,
  output logic [1:0]             win_priv,
  output logic [7:0]             win_level,
  output logic [7:0]             win_prio,
  output logic                   take_irq,
  output logic                   wake_req
);
  irq_cand_t      cand [NUM_IRQ];
  irq_cand_t      best;
  logic [IDW-1:0] best_id;
  logic [7:0]     th_eff;
  logic           take_d, wake_d;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_dec
    irq_ctl_decode #(.CTL_BITS(CTL_BITS)) u_dec (
      .pend (irq_pend[i]),
      .en   (irq_en[i]),
      .mode (irq_mode[2*i +: 2]),
      .ctl  (irq_ctl[8*i +: 8]),
      .nl_m (lvl_bits_m),
      .nl_s (lvl_bits_s),
      .nl_u (lvl_bits_u),
      .cand (cand[i])
    );
  end

  irq_rank_tree #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_tree (
    .cand    (cand),
    .best    (best),
    .best_id (best_id)
  );

  assign th_eff = ones_fill(8'(cur_thresh) << (8 - THRESH_BITS), THRESH_BITS);

  irq_take_gate u_gate (
    .best      (best),
    .cur_priv  (cur_priv),
    .cur_level (cur_level),
    .th_eff    (th_eff),
    .cur_gie   (cur_gie),
    .take      (take_d),
    .wake      (wake_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_id    <= '0;
      win_priv  <= '0;
      win_level <= '0;
      win_prio  <= '0;
      take_irq  <= 1'b0;
      wake_req  <= 1'b0;
    end else begin
      win_valid <= best.valid;
      win_id    <= best.valid ? best_id    : '0;
      win_priv  <= best.valid ? best.priv  : '0;
      win_level <= best.valid ? best.level : '0;
      win_prio  <= best.valid ? best.prio  : '0;
      take_irq  <= take_d;
      wake_req  <= wake_d;
    end
  end
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned IDW     = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_pend,
  input logic [NUM_IRQ-1:0] irq_en,
  input logic [1:0]         cur_priv,
  input logic [7:0]         cur_level,
  input logic               cur_gie,
  input logic               win_valid,
  input logic [IDW-1:0]     win_id,
  input logic [1:0]         win_priv,
  input logic [7:0]         win_level,
  input logic               take_irq,
  input logic               wake_req
);
  logic [NUM_IRQ-1:0] qual_d;
  logic [1:0]         priv_d;
  logic [7:0]         lvl_d;
  logic               gie_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_d <= '0;
      priv_d <= '0;
      lvl_d  <= '0;
      gie_d  <= 1'b0;
    end else begin
      qual_d <= irq_pend & irq_en;
      priv_d <= cur_priv;
      lvl_d  <= cur_level;
      gie_d  <= cur_gie;
    end
  end

  // R1
  win_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> qual_d[win_id]);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (!take_irq && !wake_req));

  // R11
  zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_level == 8'd0) |-> (!take_irq && !wake_req));

  // R9
  no_lower_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (win_priv >= priv_d));

  // R8
  same_mode_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && win_priv == priv_d) |-> (gie_d && win_level > lvl_d));

  // R10
  take_implies_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> wake_req);
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_pend  (irq_pend),
  .irq_en    (irq_en),
  .cur_priv  (cur_priv),
  .cur_level (cur_level),
  .cur_gie   (cur_gie),
  .win_valid (win_valid),
  .win_id    (win_id),
  .win_priv  (win_priv),
  .win_level (win_level),
  .take_irq  (take_irq),
  .wake_req  (wake_req)
);

// File: tb/test_irq_level_arbiter.sv
module test_irq_level_arbiter;
  localparam int N = 8;
  localparam logic [1:0] PM = 2'b11, PS = 2'b01, PU = 2'b00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]   pend, en;
  logic [2*N-1:0] mode;
  logic [8*N-1:0] ctl;
  logic [3:0] nl_m, nl_s, nl_u;
  logic [1:0] cpriv;
  logic [7:0] clvl, thr;
  logic [1:0] thr2;
  logic       gie;

  logic       v, tk, wk, n_v, n_tk, n_wk;
  logic [2:0] id, n_id;
  logic [1:0] pr, n_pr;
  logic [7:0] lv, pp, n_lv, n_pp;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_level_arbiter #(.NUM_IRQ(N)) i_irq_level_arbiter (
    .clk(clk), .rst_n(rst_n), .irq_pend(pend), .irq_en(en), .irq_mode(mode),
    .irq_ctl(ctl), .lvl_bits_m(nl_m), .lvl_bits_s(nl_s), .lvl_bits_u(nl_u),
    .cur_priv(cpriv), .cur_level(clvl), .cur_thresh(thr), .cur_gie(gie),
    .win_valid(v), .win_id(id), .win_priv(pr), .win_level(lv), .win_prio(pp),
    .take_irq(tk), .wake_req(wk));

  irq_level_arbiter #(.NUM_IRQ(N), .CTL_BITS(1), .THRESH_BITS(2)) i_irq_level_arbiter_narrow (
    .clk(clk), .rst_n(rst_n), .irq_pend(pend), .irq_en(en), .irq_mode(mode),
    .irq_ctl(ctl), .lvl_bits_m(nl_m), .lvl_bits_s(nl_s), .lvl_bits_u(nl_u),
    .cur_priv(cpriv), .cur_level(clvl), .cur_thresh(thr2), .cur_gie(gie),
    .win_valid(n_v), .win_id(n_id), .win_priv(n_pr), .win_level(n_lv), .win_prio(n_pp),
    .take_irq(n_tk), .wake_req(n_wk));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    pend = '0; en = '0; mode = '0; ctl = '0;
    nl_m = 4'd8; nl_s = 4'd8; nl_u = 4'd8;
    cpriv = PM; clvl = 8'd0; thr = 8'd0; thr2 = 2'd0; gie = 1'b1;
  endtask

  task automatic put(input int i, input logic [1:0] m, input logic [7:0] c);
    pend[i] = 1'b1; en[i] = 1'b1;
    mode[2*i +: 2] = m; ctl[8*i +: 8] = c;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_win(input string req, input int eid, input int epr,
                            input int elv, input int epp, input int etk, input int ewk);
    chk(req, "win_valid", int'(v), 1);
    chk(req, "win_id", int'(id), eid);
    chk(req, "win_priv", int'(pr), epr);
    chk(req, "win_level", int'(lv), elv);
    chk(req, "win_prio", int'(pp), epp);
    chk(req, "take_irq", int'(tk), etk);
    chk(req, "wake_req", int'(wk), ewk);
  endtask

  task automatic t_reset();
    chk("R12", "reset win_valid", int'(v), 0);
    chk("R12", "reset take_irq", int'(tk), 0);
    chk("R12", "reset wake_req", int'(wk), 0);
    chk("R12", "reset win_level", int'(lv), 0);
  endtask

  task automatic t_none();
    clear_all(); step();
    chk("R1", "idle win_valid", int'(v), 0);
    clear_all(); put(3, PM, 8'hF0); en[3] = 1'b0; step();
    chk("R1", "disabled win_valid", int'(v), 0);
    chk("R1", "disabled take", int'(tk), 0);
    clear_all(); put(3, PM, 8'hF0); pend[3] = 1'b0; step();
    chk("R1", "not pending win_valid", int'(v), 0);
  endtask

  task automatic t_priv();
    clear_all(); put(2, PU, 8'hFF); put(6, PS, 8'hFF); put(5, PM, 8'h10); step();
    expect_win("R2", 5, 3, 8'h10, 0, 1, 1);
  endtask

  task automatic t_level();
    clear_all(); nl_m = 4'd3; put(1, PM, 8'h40); put(3, PM, 8'h3F); step();
    expect_win("R3", 1, 3, 8'h5F, 8'h00, 1, 1);
    clear_all(); nl_m = 4'd0; put(1, PM, 8'h40); put(3, PM, 8'h3F); step();
    expect_win("R3", 1, 3, 8'hFF, 8'h40, 1, 1);
    clear_all(); nl_m = 4'd12; put(4, PM, 8'h21); step();
    expect_win("R3", 4, 3, 8'h21, 0, 1, 1);
  endtask

  task automatic t_prio();
    clear_all(); nl_m = 4'd4; put(0, PM, 8'h35); put(6, PM, 8'h3A); step();
    expect_win("R5", 6, 3, 8'h3F, 8'h0A, 1, 1);
    clear_all(); nl_m = 4'd4; put(0, PM, 8'h3A); put(6, PM, 8'h35); step();
    expect_win("R5", 0, 3, 8'h3F, 8'h0A, 1, 1);
  endtask

  task automatic t_tie();
    clear_all(); put(2, PM, 8'h80); put(7, PM, 8'h80); put(4, PM, 8'h80); step();
    expect_win("R6", 7, 3, 8'h80, 0, 1, 1);
  endtask

  task automatic t_take_same();
    clear_all(); put(4, PM, 8'h80); clvl = 8'h80; step();
    expect_win("R8", 4, 3, 8'h80, 0, 0, 0);
    clear_all(); put(4, PM, 8'h80); clvl = 8'h7F; step();
    expect_win("R8", 4, 3, 8'h80, 0, 1, 1);
    clear_all(); put(4, PM, 8'h80); clvl = 8'h7F; gie = 1'b0; step();
    expect_win("R10", 4, 3, 8'h80, 0, 0, 1);
    clear_all(); put(4, PM, 8'h80); thr = 8'h80; step();
    expect_win("R8", 4, 3, 8'h80, 0, 0, 0);
    clear_all(); put(4, PM, 8'h80); thr = 8'h7F; step();
    expect_win("R8", 4, 3, 8'h80, 0, 1, 1);
  endtask

  task automatic t_other_priv();
    clear_all(); cpriv = PU; gie = 1'b0; clvl = 8'hFF; thr = 8'hFF; put(1, PS, 8'h10); step();
    expect_win("R9", 1, 1, 8'h10, 0, 1, 1);
    clear_all(); cpriv = PU; put(1, PS, 8'h00); step();
    expect_win("R9", 1, 1, 8'h00, 0, 0, 0);
    clear_all(); cpriv = PM; gie = 1'b0; put(2, PS, 8'h50); step();
    expect_win("R10", 2, 1, 8'h50, 0, 0, 1);
    clear_all(); cpriv = PM; put(2, PU, 8'hF0); step();
    expect_win("R9", 2, 0, 8'hF0, 0, 0, 1);
  endtask

  task automatic t_block();
    clear_all(); cpriv = PU; put(3, PM, 8'h00); put(5, PS, 8'h90); step();
    expect_win("R11", 3, 3, 8'h00, 0, 0, 0);
  endtask

  task automatic t_latency();
    clear_all(); put(6, PM, 8'hC0); step();
    chk("R12", "first winner", int'(id), 6);
    @(negedge clk); pend = '0; put(2, PM, 8'hD0);
    #3;
    chk("R12", "held before edge", int'(id), 6);
    step();
    chk("R12", "updated after edge", int'(id), 2);
  endtask

  task automatic t_narrow();
    clear_all(); put(0, PM, 8'h55); step();
    chk("R4", "narrow level low", int'(n_lv), 8'h7F);
    chk("R7", "thresh 63 take", int'(n_tk), 1);
    clear_all(); put(0, PM, 8'h55); thr2 = 2'b01; step();
    chk("R7", "thresh 127 take", int'(n_tk), 0);
    clear_all(); put(0, PM, 8'hC0); thr2 = 2'b10; step();
    chk("R4", "narrow level high", int'(n_lv), 8'hFF);
    chk("R7", "thresh 191 take", int'(n_tk), 1);
    clear_all(); put(0, PM, 8'hC0); thr2 = 2'b11; step();
    chk("R7", "thresh 255 take", int'(n_tk), 0);
    chk("R7", "thresh 255 wake", int'(n_wk), 0);
  endtask

  initial begin
    pend = '0; en = '0; mode = '0; ctl = '0;
    nl_m = 4'd8; nl_s = 4'd8; nl_u = 4'd8;
    cpriv = PM; clvl = '0; thr = '0; thr2 = '0; gie = 1'b0;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_none();
    t_priv();
    t_level();
    t_prio();
    t_tie();
    t_take_same();
    t_other_priv();
    t_block();
    t_latency();
    t_narrow();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule